// File: doc/BRIEF.md
# Branch Target Address Cache

This block remembers where previously resolved branches went. It is indexed by the fetch address. On a hit it returns, in the same cycle, the stored branch target and a taken or not-taken prediction. A dynamic branch predictor in the fetch stage uses these results to redirect fetch early. The cache has no entry for a branch until that branch has been resolved once. The resolution logic then creates the entry through an allocate port. Every later resolution of the same branch goes through a separate update port, which moves a small saturating confidence counter and refreshes the target.

The cache is direct-mapped. Each entry holds:
- a valid flag,
- the upper fetch-address bits as a tag,
- the target,
- a 2-bit counter.

Software-driven maintenance is available in three forms:
- a global flush,
- a flush of the single entry that matches a given address,
- an enable input that forces every lookup to miss.

The cache also clears itself when any of these events occurs:
- the address-space process ID changes,
- the context ID changes,
- a global instruction-cache invalidate is performed,
- the core enters the Secure state from the Non-secure state.

Leaving the Secure state does not clear the cache.

Top module: `branch_target_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses. A miss drives hit, taken and target all to 0.
- R2: A lookup is purely combinational. It hits when the entry selected by fetch-address bits [8:2] is valid and its stored tag equals address bits [31:9]. A hit returns the stored target, and taken is 1 exactly when the counter's upper bit is 1.
- R3: An allocate writes tag, target and counter, and the entry can be looked up from the next cycle. The counter starts at 2'b10 (weakly taken) for a taken branch and at 2'b01 (weakly not-taken) otherwise.
- R4: An update to a present entry changes the counter according to the outcome:
  - A taken outcome increments the counter, saturating at 2'b11, and replaces the target with the supplied one.
  - A not-taken outcome decrements the counter, saturating at 2'b00, and keeps the target.
- R5: An update whose address has no valid entry with a matching tag changes nothing.
- R6: An allocate to an address whose index is already held by a different tag replaces that entry. The old address then misses.
- R7: A global flush invalidates all entries at the next clock edge.
- R8: A single-entry flush invalidates the entry at the given address's index only if that entry's tag matches. No other entry changes.
- R9: While enable is 0 every lookup misses. Allocates and updates are still accepted and become visible once enable returns to 1.
- R10: A change of the process-ID input, a change of the context-ID input, or a pulse on the instruction-cache invalidate input flushes the whole cache at the same edge.
- R11: A rise of secureIn (1 means Secure) flushes the whole cache. A fall of secureIn does not.
- R12: Any flush in a cycle (explicit global, single-entry, or automatic) drops that cycle's allocate and update.
- R13: When an allocate and an update target the same index in one cycle, the allocate's contents are what remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Lookup enable |
| lookupAddr | input | 30 | Fetch word address, bits [31:2] |
| lookupHit | output | 1 | Entry present and enabled |
| lookupTarget | output | 32 | Predicted target, 0 on miss |
| lookupTaken | output | 1 | Predicted taken, 0 on miss |
| allocValid | input | 1 | Create entry |
| allocAddr | input | 30 | Branch word address, bits [31:2] |
| allocTarget | input | 32 | Resolved target |
| allocTaken | input | 1 | Resolved outcome |
| updValid | input | 1 | Update existing entry |
| updAddr | input | 30 | Branch word address, bits [31:2] |
| updTarget | input | 32 | Resolved target, used when taken |
| updTaken | input | 1 | Resolved outcome |
| flushAll | input | 1 | Invalidate all entries |
| flushOne | input | 1 | Invalidate matching entry |
| flushAddr | input | 30 | Address for single flush, bits [31:2] |
| icacheInvAll | input | 1 | Global instruction-cache invalidate event |
| pidIn | input | 8 | Current address-space process ID |
| ctxIn | input | 32 | Current context ID |
| secureIn | input | 1 | 1 = Secure state |

## Verification
The counter tests step a single entry through long runs of taken and of not-taken outcomes. A wrapping counter gives different predictions from a saturating one, so these runs tell the two apart.

The aliasing tests use addresses that share an index but differ in tag. They separate a true tag compare from an index-only match on three paths: lookup, update and single-entry flush.

Each automatic flush source is triggered on its own and its effect is observed at the next lookup. Secure-state entry and exit are compared against each other. A flush and a write are issued in the same cycle to confirm that the write is discarded. An allocate and an update are issued to the same index in the same cycle to show which one remains.

// File: rtl/btac_pkg.sv
package btac_pkg;
  localparam int CNT_W = 2;

  typedef struct packed {
    logic clearAll;
    logic clearOne;
    logic allocWr;
    logic updWr;
  } btacStrobe_t;
endpackage

// File: rtl/btac_ctrl.sv
module btac_ctrl
  import btac_pkg::*;
#(
  parameter int PID_W = 8,
  parameter int CTX_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flushAll,
  input  logic             flushOne,
  input  logic             icacheInvAll,
  input  logic [PID_W-1:0] pidIn,
  input  logic [CTX_W-1:0] ctxIn,
  input  logic             secureIn,
  input  logic             allocValid,
  input  logic             updValid,
  output btacStrobe_t      strobe
);
  logic [PID_W-1:0] pidQ;
  logic [CTX_W-1:0] ctxQ;
  logic             secQ;
  logic             autoFlush;
  logic             anyFlush;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pidQ <= '0;
      ctxQ <= '0;
      secQ <= 1'b0;
    end else begin
      pidQ <= pidIn;
      ctxQ <= ctxIn;
      secQ <= secureIn;
    end
  end

  always_comb begin
    autoFlush = (pidIn != pidQ) | (ctxIn != ctxQ) | icacheInvAll | (secureIn & ~secQ);
    anyFlush  = flushAll | flushOne | autoFlush;
    strobe.clearAll = flushAll | autoFlush;
    strobe.clearOne = flushOne;
    strobe.allocWr  = allocValid & ~anyFlush;
    strobe.updWr    = updValid & ~anyFlush;
  end

  // R11
  secure_entry_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secureIn && !$past(secureIn)) |-> strobe.clearAll);

  // R12
  flush_drops_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flushAll || flushOne) |-> !(strobe.allocWr || strobe.updWr));
endmodule

// File: rtl/btac_dp.sv
module btac_dp
  import btac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TGT_W  = 32,
  parameter int IDX_W  = 7,
  parameter int OFFS_W = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  btacStrobe_t            strb,
  input  logic                   enable,
  input  logic [ADDR_W-1:OFFS_W] lookupAddr,
  output logic                   lookupHit,
  output logic [TGT_W-1:0]       lookupTarget,
  output logic                   lookupTaken,
  input  logic [ADDR_W-1:OFFS_W] allocAddr,
  input  logic [TGT_W-1:0]       allocTarget,
  input  logic                   allocTaken,
  input  logic [ADDR_W-1:OFFS_W] updAddr,
  input  logic [TGT_W-1:0]       updTarget,
  input  logic                   updTaken,
  input  logic [ADDR_W-1:OFFS_W] flushAddr
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int IDX_LO  = OFFS_W;
  localparam int TAG_LO  = OFFS_W + IDX_W;
  localparam int TAG_W   = ADDR_W - TAG_LO;
  localparam logic [CNT_W-1:0] WEAK_T  = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] WEAK_NT = WEAK_T - CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagMem [ENTRIES];
  logic [TGT_W-1:0]   tgtMem [ENTRIES];
  logic [CNT_W-1:0]   cntMem [ENTRIES];

  logic [IDX_W-1:0] lIdx, aIdx, uIdx, fIdx;
  logic [TAG_W-1:0] lTag, aTag, uTag, fTag;
  logic             lMatch, uMatch, fMatch;
  logic [CNT_W-1:0] uCntNext;

  always_comb begin
    lIdx = lookupAddr[TAG_LO-1:IDX_LO];
    aIdx = allocAddr[TAG_LO-1:IDX_LO];
    uIdx = updAddr[TAG_LO-1:IDX_LO];
    fIdx = flushAddr[TAG_LO-1:IDX_LO];
    lTag = lookupAddr[ADDR_W-1:TAG_LO];
    aTag = allocAddr[ADDR_W-1:TAG_LO];
    uTag = updAddr[ADDR_W-1:TAG_LO];
    fTag = flushAddr[ADDR_W-1:TAG_LO];
  end

  always_comb begin
    lMatch = validQ[lIdx] && (tagMem[lIdx] == lTag);
    uMatch = validQ[uIdx] && (tagMem[uIdx] == uTag);
    fMatch = validQ[fIdx] && (tagMem[fIdx] == fTag);
  end

  always_comb begin
    lookupHit    = enable && lMatch;
    lookupTarget = lookupHit ? tgtMem[lIdx] : '0;
    lookupTaken  = lookupHit && cntMem[lIdx][CNT_W-1];
  end

  always_comb begin
    uCntNext = cntMem[uIdx];
    if (updTaken) begin
      if (uCntNext != CNT_MAX) uCntNext = uCntNext + CNT_W'(1);
    end else begin
      if (uCntNext != '0) uCntNext = uCntNext - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (strb.clearAll) begin
      validQ <= '0;
    end else begin
      if (strb.clearOne && fMatch) validQ[fIdx] <= 1'b0;
      if (strb.allocWr) validQ[aIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.updWr && uMatch) begin
      cntMem[uIdx] <= uCntNext;
      if (updTaken) tgtMem[uIdx] <= updTarget;
    end
    if (strb.allocWr) begin
      tagMem[aIdx] <= aTag;
      tgtMem[aIdx] <= allocTarget;
      cntMem[aIdx] <= allocTaken ? WEAK_T : WEAK_NT;
    end
  end

  // R9
  hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !lookupHit);

  // R2
  taken_needs_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupTaken |-> lookupHit);

  // R7
  flush_all_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> !lookupHit);
endmodule

// File: rtl/branch_target_cache.sv
module branch_target_cache
  import btac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TGT_W  = 32,
  parameter int IDX_W  = 7,
  parameter int PID_W  = 8,
  parameter int CTX_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [ADDR_W-1:2] lookupAddr,
  output logic              lookupHit,
  output logic [TGT_W-1:0]  lookupTarget,
  output logic              lookupTaken,
  input  logic              allocValid,
  input  logic [ADDR_W-1:2] allocAddr,
  input  logic [TGT_W-1:0]  allocTarget,
  input  logic              allocTaken,
  input  logic              updValid,
  input  logic [ADDR_W-1:2] updAddr,
  input  logic [TGT_W-1:0]  updTarget,
  input  logic              updTaken,
  input  logic              flushAll,
  input  logic              flushOne,
  input  logic [ADDR_W-1:2] flushAddr,
  input  logic              icacheInvAll,
  input  logic [PID_W-1:0]  pidIn,
  input  logic [CTX_W-1:0]  ctxIn,
  input  logic              secureIn
);
  btacStrobe_t strobe;

  btac_ctrl #(.PID_W(PID_W), .CTX_W(CTX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .flushAll(flushAll), .flushOne(flushOne),
    .icacheInvAll(icacheInvAll), .pidIn(pidIn), .ctxIn(ctxIn),
    .secureIn(secureIn), .allocValid(allocValid), .updValid(updValid),
    .strobe(strobe)
  );

  btac_dp #(.ADDR_W(ADDR_W), .TGT_W(TGT_W), .IDX_W(IDX_W), .OFFS_W(2)) uDp (
    .clk(clk), .rstN(rstN), .strb(strobe), .enable(enable),
    .lookupAddr(lookupAddr), .lookupHit(lookupHit),
    .lookupTarget(lookupTarget), .lookupTaken(lookupTaken),
    .allocAddr(allocAddr), .allocTarget(allocTarget), .allocTaken(allocTaken),
    .updAddr(updAddr), .updTarget(updTarget), .updTaken(updTaken),
    .flushAddr(flushAddr)
  );
endmodule

// File: tb/sim_branch_target_cache.sv
module sim_branch_target_cache;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b1;
  logic [31:2] lookupAddr = '0;
  logic        lookupHit;
  logic [31:0] lookupTarget;
  logic        lookupTaken;
  logic        allocValid = 1'b0;
  logic [31:2] allocAddr = '0;
  logic [31:0] allocTarget = '0;
  logic        allocTaken = 1'b0;
  logic        updValid = 1'b0;
  logic [31:2] updAddr = '0;
  logic [31:0] updTarget = '0;
  logic        updTaken = 1'b0;
  logic        flushAll = 1'b0;
  logic        flushOne = 1'b0;
  logic [31:2] flushAddr = '0;
  logic        icacheInvAll = 1'b0;
  logic [7:0]  pidIn = '0;
  logic [31:0] ctxIn = '0;
  logic        secureIn = 1'b0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  branch_target_cache u0 (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic look(input logic [31:0] addr, input logic eh,
                      input logic [31:0] et, input logic ek, input string req);
    lookupAddr = addr[31:2];
    #2;
    checks++;
    if (lookupHit !== eh || lookupTarget !== et || lookupTaken !== ek) begin
      errors++;
      $display("FAIL %s addr=%h actual hit=%b tgt=%h tk=%b expected hit=%b tgt=%h tk=%b",
               req, addr, lookupHit, lookupTarget, lookupTaken, eh, et, ek);
    end
  endtask

  task automatic doAlloc(input logic [31:0] addr, input logic [31:0] tgt, input logic tk);
    allocValid = 1'b1; allocAddr = addr[31:2]; allocTarget = tgt; allocTaken = tk;
    tick();
    allocValid = 1'b0;
  endtask

  task automatic doUpd(input logic [31:0] addr, input logic [31:0] tgt, input logic tk);
    updValid = 1'b1; updAddr = addr[31:2]; updTarget = tgt; updTaken = tk;
    tick();
    updValid = 1'b0;
  endtask

  task automatic t_reset();
    look(32'h0000_1000, 0, 0, 0, "R1");
    look(32'h0000_0100, 0, 0, 0, "R1");
  endtask

  task automatic t_alloc();
    doAlloc(32'h100, 32'hAAAA_0000, 1);
    look(32'h100, 1, 32'hAAAA_0000, 1, "R3 weak taken");
    doAlloc(32'h104, 32'hBBBB_0000, 0);
    look(32'h104, 1, 32'hBBBB_0000, 0, "R3 weak not-taken");
    look(32'h108, 0, 0, 0, "R2 miss");
  endtask

  task automatic t_update();
    doUpd(32'h104, 32'h1, 0);
    look(32'h104, 1, 32'hBBBB_0000, 0, "R4 dec to 0");
    doUpd(32'h104, 32'h2, 0);
    doUpd(32'h104, 32'hCCCC_0000, 1);
    look(32'h104, 1, 32'hCCCC_0000, 0, "R4 sat at 0 then inc");
    doUpd(32'h104, 32'hCCCC_0000, 1);
    look(32'h104, 1, 32'hCCCC_0000, 1, "R4 inc to 2");
    doUpd(32'h104, 32'hCCCC_0000, 1);
    doUpd(32'h104, 32'hCCCC_0000, 1);
    doUpd(32'h104, 32'hCCCC_0000, 0);
    look(32'h104, 1, 32'hCCCC_0000, 1, "R4 sat at 3 then dec");
    doUpd(32'h104, 32'hDDDD_0000, 0);
    look(32'h104, 1, 32'hCCCC_0000, 0, "R4 not-taken keeps target");
  endtask

  task automatic t_updMiss();
    doUpd(32'h204, 32'hEEEE_0000, 1);
    look(32'h204, 0, 0, 0, "R5 update absent");
    doUpd(32'h300, 32'hEEEE_0000, 0);
    doUpd(32'h300, 32'hEEEE_0000, 0);
    look(32'h100, 1, 32'hAAAA_0000, 1, "R5 tag mismatch update ignored");
  endtask

  task automatic t_alias();
    doAlloc(32'h300, 32'h3333_0000, 0);
    look(32'h300, 1, 32'h3333_0000, 0, "R6 new alias");
    look(32'h100, 0, 0, 0, "R6 old evicted");
    doAlloc(32'h100, 32'hAAAA_0000, 1);
  endtask

  task automatic t_flushOne();
    flushOne = 1'b1; flushAddr = 32'h300 >> 2;
    tick();
    flushOne = 1'b0;
    look(32'h100, 1, 32'hAAAA_0000, 1, "R8 tag mismatch kept");
    flushOne = 1'b1; flushAddr = 32'h100 >> 2;
    tick();
    flushOne = 1'b0;
    look(32'h100, 0, 0, 0, "R8 match flushed");
    look(32'h104, 1, 32'hCCCC_0000, 0, "R8 neighbour kept");
  endtask

  task automatic t_enable();
    enable = 1'b0;
    look(32'h104, 0, 0, 0, "R9 disabled miss");
    doAlloc(32'h400, 32'h4444_0000, 1);
    look(32'h400, 0, 0, 0, "R9 disabled alloc hidden");
    enable = 1'b1;
    look(32'h400, 1, 32'h4444_0000, 1, "R9 alloc while disabled kept");
  endtask

  task automatic t_flushAll();
    flushAll = 1'b1;
    tick();
    flushAll = 1'b0;
    look(32'h104, 0, 0, 0, "R7 global flush");
    look(32'h400, 0, 0, 0, "R7 global flush");
  endtask

  task automatic t_priority();
    flushAll = 1'b1;
    doAlloc(32'h500, 32'h5555_0000, 0);
    flushAll = 1'b0;
    look(32'h500, 0, 0, 0, "R12 alloc dropped");
    doAlloc(32'h500, 32'h5555_0000, 0);
    flushOne = 1'b1; flushAddr = 32'h600 >> 2;
    doUpd(32'h500, 32'h6666_0000, 1);
    flushOne = 1'b0;
    look(32'h500, 1, 32'h5555_0000, 0, "R12 update dropped");
  endtask

  task automatic t_auto();
    doAlloc(32'h800, 32'h8888_0000, 1);
    pidIn = 8'h05;
    tick();
    look(32'h800, 0, 0, 0, "R10 pid change");
    doAlloc(32'h800, 32'h8888_0000, 1);
    look(32'h800, 1, 32'h8888_0000, 1, "R10 stable pid");
    ctxIn = 32'h0000_0042;
    tick();
    look(32'h800, 0, 0, 0, "R10 ctx change");
    doAlloc(32'h800, 32'h8888_0000, 1);
    icacheInvAll = 1'b1;
    tick();
    icacheInvAll = 1'b0;
    look(32'h800, 0, 0, 0, "R10 icache invalidate");
  endtask

  task automatic t_secure();
    doAlloc(32'h900, 32'h9999_0000, 1);
    secureIn = 1'b1;
    tick();
    look(32'h900, 0, 0, 0, "R11 enter secure");
    doAlloc(32'h900, 32'h9999_0000, 1);
    secureIn = 1'b0;
    tick();
    look(32'h900, 1, 32'h9999_0000, 1, "R11 leave secure kept");
  endtask

  task automatic t_same();
    doAlloc(32'h700, 32'h7777_0000, 1);
    allocValid = 1'b1; allocAddr = 32'h700 >> 2; allocTarget = 32'h7070_0000; allocTaken = 1'b0;
    updValid = 1'b1; updAddr = 32'h700 >> 2; updTarget = 32'h0707_0000; updTaken = 1'b1;
    tick();
    allocValid = 1'b0; updValid = 1'b0;
    look(32'h700, 1, 32'h7070_0000, 0, "R13 alloc wins");
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tick();
    t_reset();
    t_alloc();
    t_update();
    t_updMiss();
    t_alias();
    t_flushOne();
    t_enable();
    t_flushAll();
    t_priority();
    t_auto();
    t_secure();
    t_same();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule